// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core that runs a small load/store instruction subset: word load, word store, branch-if-equal, and the register-to-register operations add, subtract, bitwise and, bitwise or. Every instruction passes through five stages: fetch, decode, execute, memory access and writeback. A pipeline register separates each pair of stages. The control word is decoded once, in decode, and then moves down the pipeline with its instruction. Each stage uses only the fields that belong to it. The destination register number also travels with the instruction, so that it reaches the register file in the same cycle as its result.

The core has no forwarding and no interlocks. Software must place at least two independent instructions or nops between a register write and the next read of that register. The register file is written before it is read within a cycle, so a reader three instruction slots behind the writer sees the new value. Branches are resolved in the memory stage. A taken branch discards the three instructions fetched behind it, so none of them can write a register or memory.

The instruction and data memories are internal word arrays. A load port fills them while the core is held in reset. Three groups of outputs show progress: every register write, every memory store, and the fetch address.

Top module: `fivestage_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the fetch address reads 0 and neither a register write nor a store is reported.
- R2: Encoding fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. With op 000000, funct 100000 / 100010 / 100100 / 100101 writes rs+rt, rs-rt, rs&rt or rs|rt into register rd.
- R3: Op 100011 writes to register rt the data word at byte address rs plus the sign-extended 16-bit immediate in [15:0]. Negative offsets are included.
- R4: Op 101011 stores register rt at byte address rs + sign-extended immediate. The store is shown on the store outputs, and a later load from that address returns the stored value.
- R5: Register 0 always reads as zero. An instruction that targets register 0 produces no reported register write.
- R6: A register written by one instruction is read correctly by the instruction three slots later, which is in decode during the writer's writeback cycle.
- R7: Op 000100 with equal rs and rt redirects fetch to PC+4 + (sign-extended immediate << 2), forward or backward. None of the three instructions behind it writes a register or memory.
- R8: When no branch is taken, the fetch address advances by 4 each cycle. A branch with unequal operands falls through and squashes nothing.
- R9: Any other opcode, any other funct under op 000000, and the all-zero word act as nops that change no register and no memory.
- R10: Register writes are reported in program order, one per cycle at most, each with its own destination number. The first instruction after reset reports its write after the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of PC and pipeline registers |
| ld_imem_we | input | 1 | Write ld_data into instruction memory word ld_addr |
| ld_dmem_we | input | 1 | Write ld_data into data memory word ld_addr |
| ld_addr | input | LD_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current fetch address |
| wb_valid_o | output | 1 | A register write to a nonzero register occurs this cycle |
| wb_reg_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value written |
| st_valid_o | output | 1 | A data memory store occurs this cycle |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Stored word |

## Verification
Any fault inside the core shows up in the writeback stream. A wrong control bit, a wrong destination number or a missed write produces an extra, missing or wrong register write. Such an error surfaces within four cycles of the faulty instruction entering decode, or at the latest when a dependent instruction exposes the stale value. A failed squash after a taken branch produces a write or a store in the three slots behind the branch, and that is visible in the cycle it happens. The bench checks a queue of expected writes and stores against the stream. It also checks the fetch address and the latency of the first write directly.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_to_reg;
    logic    mem_write;
    logic    branch;
    alu_op_e alu_op;
    logic    alu_src;
    logic    reg_dst;
  } ctrl_t;
endpackage

// File: rtl/core_decoder.sv
module core_decoder
  import core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_RTYPE: begin
        ctrl.reg_dst = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_OR;  end
          default: ctrl = '0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.alu_op     = ALU_ADD;
      end
      OP_STORE: begin
        ctrl.mem_write = 1'b1;
        ctrl.alu_src   = 1'b1;
        ctrl.alu_op    = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] ra1,
  input  logic [ADDR_W-1:0] ra2,
  output logic [W-1:0]      rd1,
  output logic [W-1:0]      rd2,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [W-1:0]      wd
);
  localparam int NREG = 1 << ADDR_W;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  // write-first: a same-cycle write is visible to the reader
  always_comb begin
    if (ra1 == '0)                 rd1 = '0;
    else if (we && wa == ra1)      rd1 = wd;
    else                           rd1 = regs[ra1];
    if (ra2 == '0)                 rd2 = '0;
    else if (we && wa == ra2)      rd2 = wd;
    else                           rd2 = regs[ra2];
  end
endmodule

// File: rtl/fivestage_core.sv
module fivestage_core
  import core_pkg::*;
#(
  parameter int   IMEM_WORDS = 64,
  parameter int   DMEM_WORDS = 64,
  localparam int  IA    = $clog2(IMEM_WORDS),
  localparam int  DA    = $clog2(DMEM_WORDS),
  localparam int  LD_AW = (IA > DA) ? IA : DA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_imem_we,
  input  logic             ld_dmem_we,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic [31:0]      pc_o,
  output logic             wb_valid_o,
  output logic [RIDX-1:0]  wb_reg_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             st_valid_o,
  output logic [31:0]      st_addr_o,
  output logic [XLEN-1:0]  st_data_o
);
  // ---------------- memories ----------------
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  logic [31:0] pc_f, pc_plus4_f, pc_next;
  logic        pcsrc_m;
  logic [31:0] btarget_m;

  assign pc_plus4_f = pc_f + 32'd4;
  assign pc_next    = pcsrc_m ? btarget_m : pc_plus4_f;

  always_ff @(posedge clk) begin
    if (rst) pc_f <= '0;
    else     pc_f <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_addr[IA-1:0]] <= ld_data;
  end

  // fetch/decode register
  logic [31:0] instr_d, pc_plus4_d;
  always_ff @(posedge clk) begin
    if (rst || pcsrc_m) begin
      instr_d    <= '0;
      pc_plus4_d <= '0;
    end else begin
      instr_d    <= imem[pc_f[IA+1:2]];
      pc_plus4_d <= pc_plus4_f;
    end
  end

  // ---------------- decode ----------------
  ctrl_t           ctrl_d;
  logic [XLEN-1:0] rd1_d, rd2_d, simm_d;
  logic            reg_write_w;
  logic [RIDX-1:0] dest_w;
  logic [XLEN-1:0] result_w;

  core_decoder u_dec (
    .op    (instr_d[31:26]),
    .funct (instr_d[5:0]),
    .ctrl  (ctrl_d)
  );

  core_regfile #(.W(XLEN), .ADDR_W(RIDX)) u_rf (
    .clk (clk),
    .ra1 (instr_d[25:21]),
    .ra2 (instr_d[20:16]),
    .rd1 (rd1_d),
    .rd2 (rd2_d),
    .we  (reg_write_w),
    .wa  (dest_w),
    .wd  (result_w)
  );

  assign simm_d = {{(XLEN-16){instr_d[15]}}, instr_d[15:0]};

  // decode/execute register
  ctrl_t           ctrl_e;
  logic [XLEN-1:0] rd1_e, rd2_e, simm_e;
  logic [RIDX-1:0] rt_e, rd_e;
  logic [31:0]     pc_plus4_e;
  always_ff @(posedge clk) begin
    if (rst || pcsrc_m) begin
      ctrl_e <= '0;
    end else begin
      ctrl_e <= ctrl_d;
    end
    rd1_e      <= rd1_d;
    rd2_e      <= rd2_d;
    simm_e     <= simm_d;
    rt_e       <= instr_d[20:16];
    rd_e       <= instr_d[15:11];
    pc_plus4_e <= pc_plus4_d;
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] srcb_e, alu_y_e;
  logic            zero_e;
  logic [RIDX-1:0] dest_e;
  logic [31:0]     btarget_e;

  assign srcb_e    = ctrl_e.alu_src ? simm_e : rd2_e;
  assign dest_e    = ctrl_e.reg_dst ? rd_e : rt_e;
  assign btarget_e = pc_plus4_e + {simm_e[29:0], 2'b00};

  core_alu #(.W(XLEN)) u_alu (
    .a    (rd1_e),
    .b    (srcb_e),
    .op   (ctrl_e.alu_op),
    .y    (alu_y_e),
    .zero (zero_e)
  );

  // execute/memory register
  logic            reg_write_m, mem_to_reg_m, mem_write_m, branch_m, zero_m;
  logic [XLEN-1:0] alu_out_m, wdata_m;
  logic [RIDX-1:0] dest_m;
  always_ff @(posedge clk) begin
    if (rst || pcsrc_m) begin
      reg_write_m <= 1'b0;
      mem_write_m <= 1'b0;
      branch_m    <= 1'b0;
    end else begin
      reg_write_m <= ctrl_e.reg_write;
      mem_write_m <= ctrl_e.mem_write;
      branch_m    <= ctrl_e.branch;
    end
    mem_to_reg_m <= ctrl_e.mem_to_reg;
    zero_m       <= zero_e;
    alu_out_m    <= alu_y_e;
    wdata_m      <= rd2_e;
    dest_m       <= dest_e;
    btarget_m    <= btarget_e;
  end

  // ---------------- memory ----------------
  assign pcsrc_m = branch_m & zero_m;

  always_ff @(posedge clk) begin
    if (ld_dmem_we)       dmem[ld_addr[DA-1:0]]   <= ld_data;
    else if (mem_write_m) dmem[alu_out_m[DA+1:2]] <= wdata_m;
  end

  // memory/writeback register
  logic            mem_to_reg_w;
  logic [XLEN-1:0] alu_out_w, rdata_w;
  always_ff @(posedge clk) begin
    if (rst) reg_write_w <= 1'b0;
    else     reg_write_w <= reg_write_m;
    mem_to_reg_w <= mem_to_reg_m;
    alu_out_w    <= alu_out_m;
    dest_w       <= dest_m;
    rdata_w      <= dmem[alu_out_m[DA+1:2]];
  end

  // ---------------- writeback ----------------
  assign result_w = mem_to_reg_w ? rdata_w : alu_out_w;

  assign pc_o       = pc_f;
  assign wb_valid_o = reg_write_w && (dest_w != '0);
  assign wb_reg_o   = dest_w;
  assign wb_data_o  = result_w;
  assign st_valid_o = mem_write_m;
  assign st_addr_o  = alu_out_m;
  assign st_data_o  = wdata_m;
endmodule

// File: rtl/core_checker.sv
module core_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        pcsrc,
  input logic [31:0] btarget,
  input logic        wb_valid,
  input logic        st_valid
);
  // R1: clean state in the first cycle after reset
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == 32'd0 && !wb_valid && !st_valid));

  // R8: sequential fetch when no branch is taken
  p_seq_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    !pcsrc |=> pc == $past(pc) + 32'd4);

  // R7: taken branch redirects fetch to its target
  p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
    pcsrc |=> pc == $past(btarget));

  // R7: the slot behind a taken branch neither stores nor branches
  p_squash_mem_r7: assert property (@(posedge clk) disable iff (rst)
    pcsrc |=> (!st_valid && !pcsrc));

  // R7: the three squashed slots reach writeback without writing
  p_squash_wb_r7: assert property (@(posedge clk) disable iff (rst)
    pcsrc |-> ##2 !wb_valid ##1 !wb_valid ##1 !wb_valid);
endmodule

bind fivestage_core core_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_o),
  .pcsrc    (pcsrc_m),
  .btarget  (btarget_m),
  .wb_valid (wb_valid_o),
  .st_valid (st_valid_o)
);

// File: tb/fivestage_core_bench.sv
module fivestage_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 64;
  localparam int AW         = 6;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   pc_o, wb_data_o, st_addr_o, st_data_o;
  logic [4:0]    wb_reg_o;
  logic          wb_valid_o, st_valid_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fivestage_core u_fivestage_core (
    .clk, .rst, .ld_imem_we, .ld_dmem_we, .ld_addr, .ld_data,
    .pc_o, .wb_valid_o, .wb_reg_o, .wb_data_o,
    .st_valid_o, .st_addr_o, .st_data_o
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  logic [4:0]  exp_reg[$];
  logic [31:0] exp_val[$];
  string       exp_tag[$];
  logic [31:0] exp_saddr[$], exp_sdata[$];

  logic [31:0] prog [WORDS];
  logic [31:0] dinit[WORDS];
  int plen;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask
  task automatic expect_wb(input int r, input logic [31:0] v, input string tag);
    exp_reg.push_back(5'(r)); exp_val.push_back(v); exp_tag.push_back(tag);
  endtask

  task automatic clear_images();
    plen = 0;
    for (int i = 0; i < WORDS; i++) begin prog[i] = '0; dinit[i] = '0; end
  endtask

  // hold reset, load both memories, check reset state, release
  task automatic load_and_release();
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b1; ld_dmem_we = 1'b1; ld_addr = AW'(i);
      ld_data = prog[i];
      @(negedge clk);
      ld_imem_we = 1'b0; ld_data = dinit[i];
    end
    @(negedge clk) ld_dmem_we = 1'b0;
    @(negedge clk);
    check(pc_o == 32'd0, "R1", "pc during reset", pc_o, 32'd0);
    check(!wb_valid_o && !st_valid_o, "R1", "no activity in reset",
          {30'd0, wb_valid_o, st_valid_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic drain(input int n, input string req);
    repeat (n) @(negedge clk);
    check(exp_reg.size() == 0, req, "writes still pending", exp_reg.size(), 0);
    check(exp_saddr.size() == 0, req, "stores still pending", exp_saddr.size(), 0);
  endtask

  // monitor: compare each reported write and store against the queues
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (wb_valid_o) begin
        if (exp_reg.size() == 0) begin
          check(1'b0, "R10", "unexpected write, reg/data", {27'd0, wb_reg_o}, wb_data_o);
        end else begin
          logic [4:0]  er;
          logic [31:0] ev;
          string       et;
          er = exp_reg.pop_front(); ev = exp_val.pop_front(); et = exp_tag.pop_front();
          check(wb_reg_o == er, et, "write destination", {27'd0, wb_reg_o}, {27'd0, er});
          check(wb_data_o == ev, et, "write value", wb_data_o, ev);
        end
      end
      if (st_valid_o) begin
        if (exp_saddr.size() == 0) begin
          check(1'b0, "R7", "unexpected store, addr/data", st_addr_o, st_data_o);
        end else begin
          logic [31:0] ea, ed;
          ea = exp_saddr.pop_front(); ed = exp_sdata.pop_front();
          check(st_addr_o == ea, "R4", "store address", st_addr_o, ea);
          check(st_data_o == ed, "R4", "store data", st_data_o, ed);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // ---------- program A: arithmetic, loads, stores, r0, nops ----------
    clear_images();
    dinit[1] = 32'd8; dinit[2] = 32'd4;
    emit(enc_i(6'b100011, 0, 1, 4));          expect_wb(1, 32'd8, "R3");
    emit(enc_i(6'b100011, 0, 2, 8));          expect_wb(2, 32'd4, "R3");
    emit(32'h0); emit(32'h0);
    emit(enc_r(1, 2, 3, 6'b100000));          expect_wb(3, 32'd12, "R2_add");
    emit(enc_r(1, 2, 4, 6'b100010));          expect_wb(4, 32'd4, "R2_sub");
    emit(enc_r(1, 2, 5, 6'b100100));          expect_wb(5, 32'd0, "R2_and");
    emit(enc_r(1, 2, 13, 6'b100101));         expect_wb(13, 32'd12, "R2_or");
    emit(enc_r(1, 2, 0, 6'b100000));          // R5: write to r0 is silent
    emit(enc_r(4, 4, 13, 6'b101010));         // R9: unsupported funct
    emit(32'hFC0D_0000);                      // R9: unknown opcode, rt=13
    emit(enc_r(0, 3, 7, 6'b100000));          expect_wb(7, 32'd12, "R5");
    emit(enc_r(2, 1, 8, 6'b100010));          expect_wb(8, 32'hFFFF_FFFC, "R2_sub_neg");
    emit(enc_r(13, 0, 6, 6'b100000));         expect_wb(6, 32'd12, "R9");
    emit(enc_i(6'b101011, 0, 3, 16));
    exp_saddr.push_back(32'd16); exp_sdata.push_back(32'd12);
    emit(enc_i(6'b100011, 0, 9, 16));         expect_wb(9, 32'd12, "R4");
    emit(enc_i(6'b100011, 3, 10, -4));        expect_wb(10, 32'd4, "R3_negoff");
    emit(enc_r(1, 2, 11, 6'b100000));         expect_wb(11, 32'd12, "R6");
    emit(32'h0); emit(32'h0);
    emit(enc_r(11, 11, 12, 6'b100000));       expect_wb(12, 32'd24, "R6");
    emit(enc_i(6'b000100, 0, 0, -1));         // halt loop
    load_and_release();
    @(posedge clk); @(negedge clk);
    check(pc_o == 32'd4, "R8", "pc one cycle after reset", pc_o, 32'd4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wb_valid_o && wb_reg_o == 5'd1, "R10", "first write latency",
          {26'd0, wb_valid_o, wb_reg_o}, {26'd0, 1'b1, 5'd1});
    drain(40, "R10");

    // ---------- program B: branches ----------
    clear_images();
    dinit[0] = 32'd1;
    emit(enc_i(6'b100011, 0, 1, 0));          expect_wb(1, 32'd1, "R3");
    emit(32'h0); emit(32'h0);
    emit(enc_i(6'b000100, 1, 0, 5));          // R8: not taken
    emit(enc_r(1, 1, 2, 6'b100000));          expect_wb(2, 32'd2, "R8");
    emit(enc_i(6'b000100, 0, 0, 4));          // R7: taken to word 10
    emit(enc_r(1, 1, 3, 6'b100000));          // squashed
    emit(enc_i(6'b101011, 0, 1, 0));          // squashed store
    emit(enc_r(1, 1, 4, 6'b100000));          // squashed
    emit(enc_r(1, 1, 5, 6'b100000));          // skipped
    emit(enc_r(1, 0, 6, 6'b100101));          expect_wb(6, 32'd1, "R7");
    emit(enc_r(2, 1, 7, 6'b100000));          expect_wb(7, 32'd3, "R7");
    emit(enc_i(6'b000100, 0, 0, -1));         // R7: backward halt loop
    load_and_release();
    drain(40, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule